// File: doc/BRIEF.md
# Trace Store Micro-Op Delivery Sequencer

This controller sits between the front end and the execution back end and hands out decoded micro-ops, up to three per cycle, from a small store of trace segments. A fetch address is presented. One cycle later the sequencer looks the address up in a direct-mapped store. On a hit it streams the stored segment in execute mode. On a miss it enters build mode. In build mode it takes micro-ops from a decoder stream and writes them slot by slot into the store until the decoder marks the end of the segment or the segment is full. It then looks the address up again and delivers the new segment.

A segment may follow a branch and then continue with micro-ops of the predicted path, so a segment is only a list of slots. A slot can also carry an escape tag in place of a micro-op. The tag stands for a long instruction whose micro-ops come from a microcode ROM. When delivery reaches such a slot, the sequencer starts the ROM at the pointer held in the tag and passes the ROM's micro-ops through lane 0. When the ROM flags its last micro-op, the sequencer goes back to the stored segment at the slot after the tag.

Top module: `tcs_seq`

## Requirements
- R1: After reset, out_valid is 0, fetch_ready is 1 and dec_ready is 0.
- R2: A fetch is accepted only while fetch_ready is 1 (idle), and fetch_ready then drops. On a hit the segment is delivered from the store, and dec_ready stays 0 for the whole fetch.
- R3: On a miss, dec_ready rises and each accepted decoder item fills the next slot, where dec_esc=1 marks an escape tag. The segment closes on an item with dec_end=1 or at the sixth item, whichever comes first. The stored segment is then delivered.
- R4: Each output group holds 1 to 3 micro-ops in slot order, with lane k carried in out_uop[16k+15:16k]. The valid bits are filled from lane 0 upward (out_valid is one of 000, 001, 011, 111), and a full group of three is delivered whenever three plain slots are available.
- R5: An escape slot is never output. At that slot rom_start pulses for one cycle with rom_ptr equal to the low 4 bits of the slot's payload. ROM micro-ops then appear on lane 0 alone, with rom_ready equal to out_ready, until the one flagged rom_last is accepted.
- R6: A group never spans an escape. The first ROM micro-op and the first stored micro-op after a ROM sequence both appear in lane 0.
- R7: While out_valid is nonzero and out_ready is 0, out_valid and out_uop are held unchanged into the next cycle.
- R8: The store has 8 sets indexed by fetch_addr[2:0], tagged with fetch_addr[15:3]. A fetch with the same index and a different tag misses and replaces the resident segment.
- R9: After the last slot of a segment (stored micro-op or ROM sequence) is accepted, the sequencer returns to idle with fetch_ready at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch address presented |
| fetch_addr | input | 16 | Segment start address |
| fetch_ready | output | 1 | Sequencer idle, fetch can be taken |
| dec_valid | input | 1 | Decoder item available |
| dec_uop | input | 16 | Decoder micro-op or escape payload |
| dec_esc | input | 1 | Item is an escape tag |
| dec_end | input | 1 | Item closes the segment |
| dec_ready | output | 1 | Build mode, item accepted |
| rom_start | output | 1 | Start the microcode ROM sequence |
| rom_ptr | output | 4 | ROM sequence start pointer |
| rom_valid | input | 1 | ROM micro-op available |
| rom_uop | input | 16 | ROM micro-op |
| rom_last | input | 1 | Last micro-op of the ROM sequence |
| rom_ready | output | 1 | ROM micro-op accepted |
| out_valid | output | 3 | Per-lane valid |
| out_uop | output | 48 | Three micro-op lanes |
| out_ready | input | 1 | Back end accepts the group |

## Verification
The bench builds the block with its default parameters: 8 sets, 6 slots per segment, 3 lanes, 16-bit micro-ops and a 16-entry ROM pointer. With 8 sets, two addresses that share the low three bits can evict each other within a short run. With 6 slots and 3 lanes, segments can end by their end flag or by filling up, and a segment with no escape can leave as two full groups. The chosen addresses put escape tags in the first slot, in a middle slot and in the last slot. A random back-pressure phase exercises the hold rule, and a later phase with out_ready held high exposes full-width groups.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_LOOK   = 3'd1,
      SQ_BUILD  = 3'd2,
      SQ_STREAM = 3'd3,
      SQ_ROM    = 3'd4
   } seq_state_e;

endpackage

// File: rtl/tcs_store.sv
module tcs_store #(
   parameter int SETS   = 8,
   parameter int SLOTS  = 6,
   parameter int UOP_W  = 16,
   parameter int TAG_W  = 13,
   parameter int PTR_W  = 3,
   localparam int IDX_W = $clog2(SETS),
   localparam int SEL_W = $clog2(SLOTS),
   localparam int ENT_W = UOP_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IDX_W-1:0]         rd_set,
   input  logic [TAG_W-1:0]         rd_tag,
   output logic                     rd_hit,
   output logic [PTR_W-1:0]         rd_len,
   output logic [SLOTS*ENT_W-1:0]   rd_slots,
   input  logic [IDX_W-1:0]         wr_set,
   input  logic                     inv_en,
   input  logic                     slot_we,
   input  logic [SEL_W-1:0]         slot_idx,
   input  logic [ENT_W-1:0]         slot_data,
   input  logic                     commit_en,
   input  logic [TAG_W-1:0]         commit_tag,
   input  logic [PTR_W-1:0]         commit_len
);

   logic [SETS-1:0]  vld_r;
   logic [TAG_W-1:0] tag_r [SETS];
   logic [PTR_W-1:0] len_r [SETS];
   logic [ENT_W-1:0] slot_r [SETS][SLOTS];

   assign rd_hit = vld_r[rd_set] && (tag_r[rd_set] == rd_tag);
   assign rd_len = len_r[rd_set];

   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_rd
         assign rd_slots[g*ENT_W +: ENT_W] = slot_r[rd_set][g];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_r <= '0;
         for (int s = 0; s < SETS; s++) begin
            tag_r[s] <= '0;
            len_r[s] <= '0;
         end
      end else begin
         if (inv_en)
            vld_r[wr_set] <= 1'b0;
         if (commit_en) begin
            vld_r[wr_set] <= 1'b1;
            tag_r[wr_set] <= commit_tag;
            len_r[wr_set] <= commit_len;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int k = 0; k < SLOTS; k++)
               slot_r[s][k] <= '0;
      end else if (slot_we) begin
         slot_r[wr_set][slot_idx] <= slot_data;
      end
   end

endmodule

// File: rtl/tcs_build.sv
module tcs_build #(
   parameter int SLOTS  = 6,
   parameter int PTR_W  = 3,
   localparam int SEL_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             item_fire,
   input  logic             item_end,
   output logic [SEL_W-1:0] fill_idx,
   output logic             close,
   output logic [PTR_W-1:0] close_len
);

   logic [PTR_W-1:0] cnt_r;

   assign fill_idx  = SEL_W'(cnt_r);
   assign close     = item_fire && (item_end || (cnt_r == PTR_W'(SLOTS - 1)));
   assign close_len = cnt_r + PTR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_r <= '0;
      else if (start)
         cnt_r <= '0;
      else if (item_fire)
         cnt_r <= close ? '0 : cnt_r + PTR_W'(1);
   end

endmodule

// File: rtl/tcs_pick.sv
module tcs_pick #(
   parameter int SLOTS  = 6,
   parameter int LANES  = 3,
   parameter int UOP_W  = 16,
   parameter int PTR_W  = 3,
   parameter int ROM_AW = 4,
   localparam int SEL_W = $clog2(SLOTS),
   localparam int ENT_W = UOP_W + 1
) (
   input  logic [SLOTS*ENT_W-1:0] slots,
   input  logic [PTR_W-1:0]       ptr,
   input  logic [PTR_W-1:0]       len,
   output logic                   lead_esc,
   output logic [ROM_AW-1:0]      lead_rom,
   output logic [LANES-1:0]       lane_vld,
   output logic [LANES*UOP_W-1:0] lane_uop,
   output logic [PTR_W-1:0]       adv
);

   logic [ENT_W-1:0] ent [SLOTS];
   logic [ENT_W-1:0] head;

   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_split
         assign ent[g] = slots[g*ENT_W +: ENT_W];
      end
   endgenerate

   assign head     = (ptr < len) ? ent[SEL_W'(ptr)] : '0;
   assign lead_esc = (ptr < len) && head[UOP_W];
   assign lead_rom = head[ROM_AW-1:0];

   always_comb begin
      logic             blocked;
      logic [PTR_W:0]   pos;
      blocked  = 1'b0;
      adv      = '0;
      lane_vld = '0;
      lane_uop = '0;
      for (int k = 0; k < LANES; k++) begin
         pos = {1'b0, ptr} + (PTR_W+1)'(k);
         if (!blocked && (pos < {1'b0, len})) begin
            if (ent[SEL_W'(pos)][UOP_W]) begin
               blocked = 1'b1;
            end else begin
               lane_vld[k]                = 1'b1;
               lane_uop[k*UOP_W +: UOP_W] = ent[SEL_W'(pos)][UOP_W-1:0];
               adv                        = adv + PTR_W'(1);
            end
         end else begin
            blocked = 1'b1;
         end
      end
   end

endmodule

// File: rtl/tcs_seq.sv
module tcs_seq
   import tcs_pkg::*;
#(
   parameter int SETS   = 8,
   parameter int SLOTS  = 6,
   parameter int LANES  = 3,
   parameter int UOP_W  = 16,
   parameter int ADDR_W = 16,
   parameter int ROM_AW = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - IDX_W,
   localparam int PTR_W = $clog2(SLOTS + 1),
   localparam int SEL_W = $clog2(SLOTS),
   localparam int ENT_W = UOP_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fetch_valid,
   input  logic [ADDR_W-1:0]      fetch_addr,
   output logic                   fetch_ready,
   input  logic                   dec_valid,
   input  logic [UOP_W-1:0]       dec_uop,
   input  logic                   dec_esc,
   input  logic                   dec_end,
   output logic                   dec_ready,
   output logic                   rom_start,
   output logic [ROM_AW-1:0]      rom_ptr,
   input  logic                   rom_valid,
   input  logic [UOP_W-1:0]       rom_uop,
   input  logic                   rom_last,
   output logic                   rom_ready,
   output logic [LANES-1:0]       out_valid,
   output logic [LANES*UOP_W-1:0] out_uop,
   input  logic                   out_ready
);

   generate
      if (LANES < 1 || LANES > SLOTS) begin : g_bad_lanes
         $error("tcs_seq: LANES must lie in 1..SLOTS");
      end
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("tcs_seq: SETS must be a power of two, at least 2");
      end
      if (ROM_AW > UOP_W || IDX_W >= ADDR_W) begin : g_bad_width
         $error("tcs_seq: ROM_AW or ADDR_W out of range");
      end
   endgenerate

   seq_state_e        st_r;
   logic [ADDR_W-1:0] addr_r;
   logic [PTR_W-1:0]  ptr_r;

   logic [IDX_W-1:0]       cur_set;
   logic [TAG_W-1:0]       cur_tag;
   logic                   hit;
   logic [PTR_W-1:0]       seg_len;
   logic [SLOTS*ENT_W-1:0] seg_slots;

   logic                   build_start;
   logic                   dec_fire;
   logic [SEL_W-1:0]       fill_idx;
   logic                   seg_close;
   logic [PTR_W-1:0]       close_len;

   logic                   lead_esc;
   logic [ROM_AW-1:0]      lead_rom;
   logic [LANES-1:0]       pick_vld;
   logic [LANES*UOP_W-1:0] pick_uop;
   logic [PTR_W-1:0]       pick_adv;

   logic                   grp_fire;
   logic                   rom_done;

   assign cur_set = addr_r[IDX_W-1:0];
   assign cur_tag = addr_r[ADDR_W-1:IDX_W];

   assign build_start = (st_r == SQ_LOOK) && !hit;
   assign dec_ready   = (st_r == SQ_BUILD);
   assign dec_fire    = dec_ready && dec_valid;
   assign fetch_ready = (st_r == SQ_IDLE);

   tcs_store #(
      .SETS(SETS), .SLOTS(SLOTS), .UOP_W(UOP_W), .TAG_W(TAG_W), .PTR_W(PTR_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_set     (cur_set),
      .rd_tag     (cur_tag),
      .rd_hit     (hit),
      .rd_len     (seg_len),
      .rd_slots   (seg_slots),
      .wr_set     (cur_set),
      .inv_en     (build_start),
      .slot_we    (dec_fire),
      .slot_idx   (fill_idx),
      .slot_data  ({dec_esc, dec_uop}),
      .commit_en  (seg_close),
      .commit_tag (cur_tag),
      .commit_len (close_len)
   );

   tcs_build #(
      .SLOTS(SLOTS), .PTR_W(PTR_W)
   ) u_build (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (build_start),
      .item_fire (dec_fire),
      .item_end  (dec_end),
      .fill_idx  (fill_idx),
      .close     (seg_close),
      .close_len (close_len)
   );

   tcs_pick #(
      .SLOTS(SLOTS), .LANES(LANES), .UOP_W(UOP_W), .PTR_W(PTR_W), .ROM_AW(ROM_AW)
   ) u_pick (
      .slots    (seg_slots),
      .ptr      (ptr_r),
      .len      (seg_len),
      .lead_esc (lead_esc),
      .lead_rom (lead_rom),
      .lane_vld (pick_vld),
      .lane_uop (pick_uop),
      .adv      (pick_adv)
   );

   // output steering between stored trace and ROM stream
   always_comb begin
      out_valid = '0;
      out_uop   = '0;
      rom_ready = 1'b0;
      if (st_r == SQ_STREAM && !lead_esc) begin
         out_valid = pick_vld;
         out_uop   = pick_uop;
      end else if (st_r == SQ_ROM) begin
         rom_ready          = out_ready;
         out_valid[0]       = rom_valid;
         out_uop[UOP_W-1:0] = rom_uop;
      end
   end

   assign rom_start = (st_r == SQ_STREAM) && lead_esc;
   assign rom_ptr   = lead_rom;
   assign grp_fire  = (st_r == SQ_STREAM) && !lead_esc && out_ready && (pick_vld != '0);
   assign rom_done  = (st_r == SQ_ROM) && rom_valid && out_ready && rom_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_r   <= SQ_IDLE;
         addr_r <= '0;
         ptr_r  <= '0;
      end else begin
         unique case (st_r)
            SQ_IDLE: begin
               if (fetch_valid) begin
                  addr_r <= fetch_addr;
                  st_r   <= SQ_LOOK;
               end
            end
            SQ_LOOK: begin
               ptr_r <= '0;
               st_r  <= hit ? SQ_STREAM : SQ_BUILD;
            end
            SQ_BUILD: begin
               if (seg_close)
                  st_r <= SQ_LOOK;
            end
            SQ_STREAM: begin
               if (lead_esc) begin
                  st_r <= SQ_ROM;
               end else if (grp_fire) begin
                  ptr_r <= ptr_r + pick_adv;
                  if (ptr_r + pick_adv == seg_len)
                     st_r <= SQ_IDLE;
               end
            end
            SQ_ROM: begin
               if (rom_done) begin
                  ptr_r <= ptr_r + PTR_W'(1);
                  st_r  <= (ptr_r + PTR_W'(1) == seg_len) ? SQ_IDLE : SQ_STREAM;
               end
            end
            default: st_r <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tcs_seq_chk.sv
module tcs_seq_chk #(
   parameter int LANES = 3,
   parameter int UOP_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   fetch_valid,
   input logic                   fetch_ready,
   input logic                   dec_ready,
   input logic                   rom_start,
   input logic                   rom_ready,
   input logic [LANES-1:0]       out_valid,
   input logic [LANES*UOP_W-1:0] out_uop,
   input logic                   out_ready
);

   // R2
   fetch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_ready) |=> !fetch_ready);

   // R3
   build_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_ready |-> (out_valid == '0 && !fetch_ready));

   // R4
   lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid & (out_valid + 1'b1)) == '0);

   // R5
   rom_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_start |=> !rom_start);

   // R5
   rom_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_ready |-> $countones(out_valid) <= 1 && out_valid[LANES-1:1] == '0);

   // R7
   hold_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid != '0 && !out_ready) |=> ($stable(out_valid) && $stable(out_uop)));

endmodule

bind tcs_seq tcs_seq_chk #(.LANES(LANES), .UOP_W(UOP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .fetch_ready (fetch_ready),
   .dec_ready   (dec_ready),
   .rom_start   (rom_start),
   .rom_ready   (rom_ready),
   .out_valid   (out_valid),
   .out_uop     (out_uop),
   .out_ready   (out_ready)
);

// File: tb/tb_tcs_seq.sv
module tb_tcs_seq;

   localparam int LANES = 3;
   localparam int UW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fetch_valid = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic fetch_ready;
   logic dec_valid = 1'b0;
   logic [15:0] dec_uop = '0;
   logic dec_esc = 1'b0;
   logic dec_end = 1'b0;
   logic dec_ready;
   logic rom_start;
   logic [3:0] rom_ptr;
   logic rom_valid = 1'b0;
   logic [15:0] rom_uop;
   logic rom_last;
   logic rom_ready;
   logic [LANES-1:0] out_valid;
   logic [LANES*UW-1:0] out_uop;
   logic out_ready = 1'b1;

   always #5 clk = ~clk;

   tcs_seq dut (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
      .dec_valid(dec_valid), .dec_uop(dec_uop), .dec_esc(dec_esc), .dec_end(dec_end),
      .dec_ready(dec_ready),
      .rom_start(rom_start), .rom_ptr(rom_ptr), .rom_valid(rom_valid), .rom_uop(rom_uop),
      .rom_last(rom_last), .rom_ready(rom_ready),
      .out_valid(out_valid), .out_uop(out_uop), .out_ready(out_ready)
   );

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [15:0] uop;
      bit          lane0;
   } exp_t;

   exp_t        expq[$];
   logic [17:0] decq[$];
   int          dec_acc = 0;
   bit          free_run = 1'b0;
   logic [7:0]  lfsr = 8'hA5;
   bit          saw_full = 1'b0;
   int          model_tag[8];

   // ROM model: sequence length (ptr mod 3)+1, uop = A0 & ptr & index
   logic [3:0] rom_base = '0;
   logic [3:0] rom_cnt = '0;

   function automatic int rom_len(logic [3:0] b);
      return int'(b) % 3 + 1;
   endfunction

   assign rom_uop  = {8'hA0, rom_base, rom_cnt};
   assign rom_last = (int'(rom_cnt) == rom_len(rom_base) - 1);

   always @(posedge clk) begin
      if (!rst_n) begin
         rom_valid <= 1'b0;
      end else if (rom_start) begin
         rom_base  <= rom_ptr;
         rom_cnt   <= '0;
         rom_valid <= 1'b1;
      end else if (rom_valid && rom_ready) begin
         if (rom_last) rom_valid <= 1'b0;
         else          rom_cnt   <= rom_cnt + 4'd1;
      end
   end

   // back-pressure source
   always @(posedge clk) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= free_run | lfsr[0] | lfsr[2];
   end

   // decoder stub
   always @(posedge clk) begin
      if (rst_n && dec_valid && dec_ready) begin
         void'(decq.pop_front());
         dec_acc++;
      end
   end

   always @(negedge clk) begin
      dec_valid = (decq.size() > 0);
      if (decq.size() > 0) {dec_esc, dec_end, dec_uop} = decq[0];
      else {dec_esc, dec_end, dec_uop} = '0;
   end

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor / scoreboard
   bit                 hold_prev = 1'b0;
   logic [LANES-1:0]   hold_v;
   logic [LANES*UW-1:0] hold_u;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_prev) begin
            checks++;
            if (out_valid !== hold_v || out_uop !== hold_u) begin
               errors++;
               $display("FAIL R7 held group changed: valid %b uop %h expected %b %h",
                        out_valid, out_uop, hold_v, hold_u);
            end
         end
         hold_prev = (out_valid != '0) && !out_ready;
         hold_v    = out_valid;
         hold_u    = out_uop;
         if (out_valid != '0 && out_ready) begin
            checks++;
            if (!(out_valid inside {3'b001, 3'b011, 3'b111})) begin
               errors++;
               $display("FAIL R4 lane pattern %b expected contiguous from lane 0", out_valid);
            end
            if (out_valid == 3'b111) saw_full = 1'b1;
            for (int k = 0; k < LANES; k++) begin
               if (out_valid[k]) begin
                  checks++;
                  if (expq.size() == 0) begin
                     errors++;
                     $display("FAIL R4 unexpected uop %h lane %0d expected none",
                              out_uop[k*UW +: UW], k);
                  end else begin
                     exp_t e;
                     e = expq.pop_front();
                     if (out_uop[k*UW +: UW] !== e.uop) begin
                        errors++;
                        $display("FAIL R5 uop order lane %0d: got %h expected %h",
                                 k, out_uop[k*UW +: UW], e.uop);
                     end
                     if (e.lane0 && k != 0) begin
                        errors++;
                        $display("FAIL R6 uop %h in lane %0d expected lane 0", e.uop, k);
                     end
                  end
               end
            end
         end
      end
   end

   // segment content generated from the address
   function automatic int seg_items(logic [15:0] a);
      return int'(a) % 6 + 1;
   endfunction

   function automatic bit item_esc(logic [15:0] a, int i);
      return ((int'(a) >> 1) + i) % 4 == 3;
   endfunction

   task automatic do_fetch(input logic [15:0] a);
      int  n;
      int  acc0;
      int  waitc;
      int  set;
      bit  exp_hit;
      bit  after_rom;
      n       = seg_items(a);
      set     = int'(a[2:0]);
      exp_hit = (model_tag[set] == int'(a[15:3]));
      model_tag[set] = int'(a[15:3]);
      after_rom = 1'b0;
      for (int i = 0; i < n; i++) begin
         logic [15:0] u;
         bit          esc;
         bit          fin;
         esc = item_esc(a, i);
         fin = (i == n - 1) && (n < 6);
         if (esc) begin
            logic [3:0] p;
            p = 4'((int'(a) + i) & 15);
            u = {12'h000, p};
            for (int r = 0; r < rom_len(p); r++)
               expq.push_back('{uop: {8'hA0, p, 4'(r)}, lane0: 1'b1});
            after_rom = 1'b1;
         end else begin
            u = {a[7:0], 4'h5, 4'(i)};
            expq.push_back('{uop: u, lane0: after_rom});
            after_rom = 1'b0;
         end
         if (!exp_hit) decq.push_back({esc, fin, u});
      end
      @(negedge clk);
      while (!fetch_ready) @(negedge clk);
      acc0        = dec_acc;
      fetch_valid = 1'b1;
      fetch_addr  = a;
      @(negedge clk);
      fetch_valid = 1'b0;
      checks++;
      if (fetch_ready !== 1'b0) begin
         errors++;
         $display("FAIL R2 fetch_ready after accept: got %b expected 0", fetch_ready);
      end
      waitc = 0;
      while (!(expq.size() == 0 && fetch_ready)) begin
         @(negedge clk);
         waitc++;
         if (waitc > 400) begin
            errors++;
            $display("FAIL R3 fetch %h stalled: %0d uops left expected 0", a, expq.size());
            report();
         end
      end
      checks++;
      if (fetch_ready !== 1'b1) begin
         errors++;
         $display("FAIL R9 not idle after segment: got %b expected 1", fetch_ready);
      end
      checks++;
      if (dec_acc - acc0 != (exp_hit ? 0 : n)) begin
         errors++;
         $display("FAIL R8 addr %h decoder items taken: got %0d expected %0d (hit=%0d)",
                  a, dec_acc - acc0, exp_hit ? 0 : n, exp_hit);
      end
      checks++;
      if (decq.size() != 0) begin
         errors++;
         $display("FAIL R3 decoder queue left: got %0d expected 0", decq.size());
         decq.delete();
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired: got running expected finished");
      report();
   end

   initial begin
      for (int s = 0; s < 8; s++) model_tag[s] = -1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      checks++;
      if (out_valid !== '0 || fetch_ready !== 1'b1 || dec_ready !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: valid %b fetch_ready %b dec_ready %b expected 000 1 0",
                  out_valid, fetch_ready, dec_ready);
      end
      // random back-pressure: builds, hits, escapes first/middle/last, eviction R8
      do_fetch(16'h0005);
      do_fetch(16'h000B);
      do_fetch(16'h0011);
      do_fetch(16'h0017);
      do_fetch(16'h0005);
      do_fetch(16'h001D);
      do_fetch(16'h0005);
      do_fetch(16'h000B);
      do_fetch(16'h0022);
      do_fetch(16'h0013);
      do_fetch(16'h0017);
      // full-rate phase
      free_run = 1'b1;
      repeat (2) @(negedge clk);
      do_fetch(16'h0011);
      do_fetch(16'h0029);
      do_fetch(16'h0011);
      do_fetch(16'h000B);
      do_fetch(16'h0017);
      checks++;
      if (!saw_full) begin
         errors++;
         $display("FAIL R4 full group never seen: got 0 expected 1");
      end
      repeat (4) @(negedge clk);
      report();
   end

endmodule